// File: doc/BRIEF.md
# Link Direction Controller Pair

This block decides, cycle by cycle, which end of one shared two-way link between neighbouring mesh routers is allowed to drive it. One controller sits at each end. The two are built from the same module with opposite priority settings: the upper end (hi) has high priority, the lower end (lo) has low priority. Each controller forwards its local channel request to the far end as a request wire, and both ends evaluate the same pair of request wires, so ownership of the link moves atomically from one end to the other on a single clock edge.

Each end is in one of three states. Receiving (rx_en high) means the far end may drive the link. Transmitting (tx_en high) means this end may drive it. The turnaround state has both enables low; an end that has just won the link spends at least one cycle there before it drives. After reset the hi end owns the link and the lo end receives. An owner that stops requesting while the far end requests gives the link away. An owner that keeps requesting holds it. The exception is a lo owner whose request rises in the same cycle as a hi request while the hi end is already asking: the hi end wins that tie.

Top module: `link_dir_pair`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, hi_tx_en=1, hi_rx_en=0, lo_tx_en=0, lo_rx_en=1.
- R2: State encoding per end: transmitting is tx_en=1 rx_en=0, receiving is tx_en=0 rx_en=1, turnaround is tx_en=0 rx_en=0. tx_en and rx_en are never both 1.
- R3: hi_out_req equals hi_chan_req and lo_out_req equals lo_chan_req in the same cycle.
- R4: hi_tx_en and lo_tx_en are never both 1.
- R5: An end that owns the link (rx_en=0) gives it up when, at a clock edge, its own channel request is 0 and the far end's request is 1. Its rx_en is 1 from the next cycle.
- R6: A receiving end whose request is 1 while the far end's request is 0 enters turnaround on the next edge. If it is not released on the edge after that, it is transmitting.
- R7: An owner whose request is 1 keeps the link while the far end also requests, except in the R8 case.
- R8: If lo owns the link, lo_chan_req was 0 in the previous cycle, and both requests are 1 now, the link passes to hi on the next edge: lo receives, and hi goes through turnaround and then transmits.
- R9: If hi owns the link and both requests rise together, hi keeps the link and lo stays receiving.
- R10: At every cycle exactly one end owns the link: hi_rx_en and lo_rx_en differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_chan_req | input | 1 | Routing logic at the hi end wants the link |
| lo_chan_req | input | 1 | Routing logic at the lo end wants the link |
| hi_out_req | output | 1 | Request wire driven from the hi end to the lo end |
| lo_out_req | output | 1 | Request wire driven from the lo end to the hi end |
| hi_tx_en | output | 1 | hi end may drive the link |
| hi_rx_en | output | 1 | hi end receives from the link |
| lo_tx_en | output | 1 | lo end may drive the link |
| lo_rx_en | output | 1 | lo end receives from the link |

## Verification
A release at one end and a take at the other fall on the same edge. A tie-break and an ownership hold can also meet in one cycle, when both requests are high while lo owns the link. The bench provokes both cases with directed sequences: a lone request against an idle owner, and both requests rising together under each owner. It then runs long random request bursts that often toggle both requests in one cycle. An owner-based model in the bench judges every cycle, and exclusive ownership is also checked directly at the enables.

// File: rtl/link_dir_pkg.sv
package link_dir_pkg;

  typedef enum logic [1:0] {
    LD_RECV = 2'b01,
    LD_TURN = 2'b00,
    LD_XMIT = 2'b10
  } ld_state_t;

  function automatic logic ld_drives(input ld_state_t s);
    return s == LD_XMIT;
  endfunction

  function automatic logic ld_listens(input ld_state_t s);
    return s == LD_RECV;
  endfunction

endpackage

// File: rtl/link_req_delay.sv
module link_req_delay #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/link_dir_fsm.sv
module link_dir_fsm
  import link_dir_pkg::*;
#(
  parameter bit HIGH_PRIO = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_req,
  input  logic in_req,
  output logic out_req,
  output logic tx_en,
  output logic rx_en
);
  localparam ld_state_t RESET_ST = HIGH_PRIO ? LD_XMIT : LD_RECV;

  ld_state_t state_q, state_d;
  logic      lo_req_now;
  logic      lo_req_prev;
  logic      take_link;
  logic      give_link;

  // previous-cycle request of the low-priority end, seen identically at both ends
  assign lo_req_now = HIGH_PRIO ? in_req : chan_req;

  link_req_delay #(.WIDTH(1)) u_hist (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (lo_req_now),
    .q    (lo_req_prev)
  );

  // both ends evaluate the same condition, so the handover is atomic
  assign take_link = chan_req && (!in_req || (HIGH_PRIO && !lo_req_prev));
  assign give_link = in_req && (!chan_req || (!HIGH_PRIO && !lo_req_prev));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_RECV: if (take_link) state_d = LD_TURN;
      LD_TURN: state_d = give_link ? LD_RECV : LD_XMIT;
      LD_XMIT: if (give_link) state_d = LD_RECV;
      default: state_d = RESET_ST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RESET_ST;
    else        state_q <= state_d;
  end

  assign out_req = chan_req;
  assign tx_en   = ld_drives(state_q);
  assign rx_en   = ld_listens(state_q);
endmodule

// File: rtl/link_dir_pair.sv
module link_dir_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_chan_req,
  input  logic lo_chan_req,
  output logic hi_out_req,
  output logic lo_out_req,
  output logic hi_tx_en,
  output logic hi_rx_en,
  output logic lo_tx_en,
  output logic lo_rx_en
);
  localparam int unsigned NUM_ENDS = 2;

  logic [NUM_ENDS-1:0] chan_vec;
  logic [NUM_ENDS-1:0] req_vec;
  logic [NUM_ENDS-1:0] tx_vec;
  logic [NUM_ENDS-1:0] rx_vec;

  assign chan_vec = {lo_chan_req, hi_chan_req};

  for (genvar i = 0; i < NUM_ENDS; i++) begin : g_end
    link_dir_fsm #(.HIGH_PRIO(i == 0)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .chan_req(chan_vec[i]),
      .in_req  (req_vec[NUM_ENDS-1-i]),
      .out_req (req_vec[i]),
      .tx_en   (tx_vec[i]),
      .rx_en   (rx_vec[i])
    );
  end

  assign hi_out_req = req_vec[0];
  assign lo_out_req = req_vec[1];
  assign hi_tx_en   = tx_vec[0];
  assign hi_rx_en   = rx_vec[0];
  assign lo_tx_en   = tx_vec[1];
  assign lo_rx_en   = rx_vec[1];
endmodule

// File: rtl/link_dir_checker.sv
module link_dir_checker (
  input logic clk,
  input logic rst_n,
  input logic hi_chan_req,
  input logic lo_chan_req,
  input logic hi_tx_en,
  input logic hi_rx_en,
  input logic lo_tx_en,
  input logic lo_rx_en
);
  assert_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_tx_en && hi_rx_en) && !(lo_tx_en && lo_rx_en));

  assert_single_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_tx_en && lo_tx_en));

  assert_hi_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_rx_en && !hi_chan_req && lo_chan_req) |=> hi_rx_en);

  assert_lo_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_rx_en && !lo_chan_req && hi_chan_req) |=> lo_rx_en);

  assert_lo_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_rx_en && lo_chan_req && !hi_chan_req) |=> (!lo_rx_en && !lo_tx_en));

  assert_via_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_tx_en) |-> $past(!lo_tx_en && !lo_rx_en));

  assert_hi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_tx_en && hi_chan_req) |=> hi_tx_en);

  assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rx_en != lo_rx_en);
endmodule

bind link_dir_pair link_dir_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hi_chan_req(hi_chan_req),
  .lo_chan_req(lo_chan_req),
  .hi_tx_en   (hi_tx_en),
  .hi_rx_en   (hi_rx_en),
  .lo_tx_en   (lo_tx_en),
  .lo_rx_en   (lo_rx_en)
);

// File: tb/link_dir_pair_test.sv
module link_dir_pair_test;
  localparam int PERIOD    = 10;
  localparam int WATCHDOG  = 200000;
  localparam int RAND_CYC  = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi_chan_req = 1'b0;
  logic lo_chan_req = 1'b0;
  logic hi_out_req, lo_out_req, hi_tx_en, hi_rx_en, lo_tx_en, lo_rx_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // owner-based reference: owner 0 = hi, 1 = lo; turning = owner in turnaround
  int m_owner = 0;
  bit m_turning = 1'b0;
  bit m_lo_prev = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  link_dir_pair uut (
    .clk(clk), .rst_n(rst_n),
    .hi_chan_req(hi_chan_req), .lo_chan_req(lo_chan_req),
    .hi_out_req(hi_out_req), .lo_out_req(lo_out_req),
    .hi_tx_en(hi_tx_en), .hi_rx_en(hi_rx_en),
    .lo_tx_en(lo_tx_en), .lo_rx_en(lo_rx_en)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_tx(input int side);
    return (m_owner == side) && !m_turning;
  endfunction

  function automatic bit exp_rx(input int side);
    return m_owner != side;
  endfunction

  function automatic bit yields(input bit h, input bit l);
    if (m_owner == 1) return h && (!l || !m_lo_prev);
    return l && !h;
  endfunction

  task automatic compare(input string tag);
    chk(hi_tx_en == exp_tx(0), tag, "hi_tx_en", int'(hi_tx_en), int'(exp_tx(0)));
    chk(hi_rx_en == exp_rx(0), tag, "hi_rx_en", int'(hi_rx_en), int'(exp_rx(0)));
    chk(lo_tx_en == exp_tx(1), tag, "lo_tx_en", int'(lo_tx_en), int'(exp_tx(1)));
    chk(lo_rx_en == exp_rx(1), tag, "lo_rx_en", int'(lo_rx_en), int'(exp_rx(1)));
    chk(!(hi_tx_en && lo_tx_en), "R4", "both_tx", int'(hi_tx_en && lo_tx_en), 0);
  endtask

  task automatic step(input bit h, input bit l, input string tag);
    hi_chan_req = h;
    lo_chan_req = l;
    #1;
    chk(hi_out_req == h, "R3", "hi_out_req", int'(hi_out_req), int'(h));
    chk(lo_out_req == l, "R3", "lo_out_req", int'(lo_out_req), int'(l));
    if (yields(h, l)) begin
      m_owner = 1 - m_owner;
      m_turning = 1'b1;
    end else begin
      m_turning = 1'b0;
    end
    m_lo_prev = l;
    @(posedge clk);
    #2;
    compare(tag);
  endtask

  initial begin
    #(PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit h, l;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    compare("R1");                       // held in reset
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1");                       // first cycle after reset

    step(0, 0, "R1");
    step(0, 0, "R1");
    // R6: lone lo request against idle hi owner; R5: hi releases
    step(0, 1, "R6");
    step(0, 1, "R6");
    // R7: lo owner keeps link under contention
    step(1, 1, "R7");
    step(1, 1, "R7");
    step(1, 1, "R7");
    // lo owner goes quiet, then R8 tie
    step(0, 0, "R8");
    step(1, 1, "R8");
    step(1, 1, "R8");
    step(1, 1, "R8");
    // R9: hi owner idle, both rise together
    step(0, 0, "R9");
    step(1, 1, "R9");
    step(1, 1, "R9");
    // R5: hi stops, lo keeps asking
    step(0, 1, "R5");
    step(0, 1, "R5");
    // R5 back the other way, then release during turnaround
    step(1, 0, "R5");
    step(0, 1, "R5");
    step(0, 1, "R6");

    h = 1'b0;
    l = 1'b0;
    for (int c = 0; c < RAND_CYC; c++) begin
      if ($urandom_range(7) == 0) h = ~h;
      if ($urandom_range(7) == 0) l = ~l;
      if ($urandom_range(31) == 0) begin
        h = ~h;
        l = ~l;
      end
      step(h, l, "R10");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule